// File: doc/BRIEF.md
# Reloading System Tick Timer

A down-counting tick timer with a 24-bit counter, attached to a simple word-addressed register bus. Software programs a reload value, clears the current count and turns the timer on. From then on the counter steps down by one on each counting step. A step from zero loads the reload value again, so each period lasts reload+1 steps. Every such wrap sets a sticky flag, and when interrupts are enabled it also pulses an interrupt request for one cycle.

Counting steps come either from every cycle of the processor clock or only from cycles on which an external reference-enable input is high. A control bit picks the source. The timer is normally placed at offset 0x10 inside a system control region based at 0xE000E000. This block decodes only its own low address bits. The interrupt controller, priority handling and any calibration value sit outside this block.

Top module: `tick_timer_top`

## Requirements
- R1: After reset, reads of the control, reload and current-value registers all return 0, and `tick_irq` is low.
- R2: The register map, relative to the block, is: 0x0 control, 0x4 reload, 0x8 current value. In the control register, bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the source (1 = every clock cycle, 0 = only cycles with `ref_en` high) and bit 16 is the read-only wrap flag. All other control bits read 0, and writes to bit 16 have no effect. Reads of any other offset return 0.
- R3: A reload write whose data has any bit above bit 23 set is rejected and leaves the reload register unchanged. Any other reload write stores bits 23:0.
- R4: On each counting step, a nonzero counter decrements by one. A counter at 0 loads the reload value. A period therefore lasts reload+1 steps.
- R5: A step that loads from 0 with a nonzero reload sets the wrap flag. A read of the control register returns the flag and then clears it. If a wrap falls on the same cycle as that read, the read returns the old value and the flag stays set.
- R6: With bit 1 set, every wrap raises `tick_irq` for exactly one cycle, visible in the same cycle in which the flag first reads as set. With bit 1 clear, `tick_irq` stays low.
- R7: A write to the current-value register, whatever the data, sets the counter to 0 and clears the wrap flag. This write takes precedence over a wrap in the same cycle.
- R8: With bit 2 clear, the counter steps only on cycles where `ref_en` is high. With bit 2 set, it steps on every cycle.
- R9: While bit 0 is clear, the counter holds its value.
- R10: With a reload value of 0, a counter at 0 stays at 0, and neither the flag nor `tick_irq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while `bus_rd` is high |
| ref_en | input | 1 | External reference clock enable |
| tick_irq | output | 1 | One-cycle interrupt request on wrap |

## Verification
Two pairs of functions can land on the same clock edge, and each pair is set up on purpose. In the first, a control-register read falls on the exact edge where the counter wraps from 0 with a reload of 2. The bench judges the result by the read returning a clear flag, while the read that follows shows the flag still set. In the second, a current-value write is placed on a wrap edge. The bench judges it by a clear flag, a counter still at 0, and a normal wrap on the next step. The timing of each coincidence is worked out edge by edge from the reload value.

// File: rtl/tt_pkg.sv
// Package: shared widths, register offsets and control-bit positions for the
// tick timer. Assumes a 32-bit data bus and byte offsets in a 4-bit window.
package tt_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 24;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CUR    = 4'h8;

    localparam int BIT_EN   = 0;
    localparam int BIT_INT  = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    typedef struct packed {
        logic src_core;   // 1: every clock cycle, 0: reference enable
        logic int_en;     // interrupt on wrap
        logic run;        // counting enabled
    } ctrl_t;
endpackage

// File: rtl/tt_regfile.sv
// Register file: decodes bus writes into control and reload state, produces
// the one-cycle side-effect strobes (current-value write, control read) and
// builds the combinational read data. Assumes one strobe per access.
module tt_regfile
    import tt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [CW-1:0] cnt,
    input  logic          flag,
    output ctrl_t         ctrl,
    output logic [CW-1:0] reload,
    output logic          cur_wr,
    output logic          ctrl_rd
);
    localparam int PAD_W = DW - CW;

    logic ctrl_wr;
    logic reload_wr;
    logic reload_ok;

    // Address decode of the write and read strobes.
    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == OFF_CTRL);
        reload_wr = bus_wr && (bus_addr == OFF_RELOAD);
        cur_wr    = bus_wr && (bus_addr == OFF_CUR);
        ctrl_rd   = bus_rd && (bus_addr == OFF_CTRL);
    end

    // Reload data is accepted only if nothing lies above the counter width.
    always_comb begin
        reload_ok = (bus_wdata[DW-1:CW] == '0);
    end

    // Control register: only the three writable bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.run      <= bus_wdata[BIT_EN];
            ctrl.int_en   <= bus_wdata[BIT_INT];
            ctrl.src_core <= bus_wdata[BIT_SRC];
        end
    end

    // Reload register: rejected writes leave the old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (reload_wr && reload_ok) begin
            reload <= bus_wdata[CW-1:0];
        end
    end

    // Read multiplexer; unmapped offsets and idle cycles return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFF_CTRL: begin
                    bus_rdata[BIT_EN]   = ctrl.run;
                    bus_rdata[BIT_INT]  = ctrl.int_en;
                    bus_rdata[BIT_SRC]  = ctrl.src_core;
                    bus_rdata[BIT_FLAG] = flag;
                end
                OFF_RELOAD: bus_rdata = {{PAD_W{1'b0}}, reload};
                OFF_CUR:    bus_rdata = {{PAD_W{1'b0}}, cnt};
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tt_step_gen.sv
// Step generator: turns the enable and source selection into a one-cycle
// counting step. Assumes ref_en is already synchronous to clk.
module tt_step_gen
    import tt_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  ref_en,
    output logic  step
);
    // A step happens when running and the chosen source is active.
    always_comb begin
        step = ctrl.run && (ctrl.src_core || ref_en);
    end
endmodule

// File: rtl/tt_counter.sv
// Counter core: down-counter with reload on wrap, sticky wrap flag and the
// one-cycle interrupt pulse. Priority: current-value write, then a wrap,
// then the flag clear caused by a control read.
module tt_counter #(
    parameter int CW = tt_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          int_en,
    input  logic [CW-1:0] reload,
    input  logic          cur_wr,
    input  logic          ctrl_rd,
    output logic [CW-1:0] cnt,
    output logic          flag,
    output logic          irq
);
    logic at_zero;
    logic wrap;

    // A wrap is a step from zero while a nonzero reload is programmed.
    always_comb begin
        at_zero = (cnt == '0);
        wrap    = step && at_zero && (reload != '0);
    end

    // Counter value: cleared by a write, else reloaded or decremented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cur_wr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= at_zero ? reload : cnt - 1'b1;
        end
    end

    // Wrap flag: set by a wrap, cleared by a control read unless set now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (cur_wr) begin
            flag <= 1'b0;
        end else begin
            flag <= wrap || (flag && !ctrl_rd);
        end
    end

    // Interrupt pulse: one cycle after each enabled wrap edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= wrap && int_en && !cur_wr;
        end
    end
endmodule

// File: rtl/tick_timer_top.sv
// Top level of the reloading tick timer: register file, step generator and
// counter core. Assumes a single clock and synchronous active-low reset.
module tick_timer_top
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_en,
    output logic              tick_irq
);
    ctrl_t             ctrl;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              flag_q;
    logic              cur_wr;
    logic              ctrl_rd;
    logic              step;
    logic              ctrl_en;
    logic              ctrl_int;
    logic              ctrl_src;

    // Flattened control bits for observation.
    always_comb begin
        ctrl_en  = ctrl.run;
        ctrl_int = ctrl.int_en;
        ctrl_src = ctrl.src_core;
    end

    tt_regfile #(.DW(DATA_W), .CW(CNT_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt_q),
        .flag      (flag_q),
        .ctrl      (ctrl),
        .reload    (reload_q),
        .cur_wr    (cur_wr),
        .ctrl_rd   (ctrl_rd)
    );

    tt_step_gen u_step (
        .ctrl   (ctrl),
        .ref_en (ref_en),
        .step   (step)
    );

    tt_counter #(.CW(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .int_en  (ctrl_int),
        .reload  (reload_q),
        .cur_wr  (cur_wr),
        .ctrl_rd (ctrl_rd),
        .cnt     (cnt_q),
        .flag    (flag_q),
        .irq     (tick_irq)
    );
endmodule

// File: rtl/tt_checker.sv
// Checker: temporal properties of the tick timer, bound to the top level.
module tt_checker #(
    parameter int DW = tt_pkg::DATA_W,
    parameter int CW = tt_pkg::CNT_W,
    parameter int AW = tt_pkg::ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] reload_q,
    input logic          flag_q,
    input logic          tick_irq,
    input logic          ctrl_en,
    input logic          ctrl_int,
    input logic          ctrl_src,
    input logic          ref_en
);
    logic wr_cur;
    logic wr_bad_reload;

    // Bus-side view of the strobes, decoded from the ports.
    always_comb begin
        wr_cur        = bus_wr && (bus_addr == 4'h8);
        wr_bad_reload = bus_wr && (bus_addr == 4'h4) && (bus_wdata[DW-1:CW] != '0);
    end

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) tick_irq |=> !tick_irq); // R6
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) tick_irq |-> flag_q); // R6
    AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_int |=> !tick_irq); // R6
    AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_cur |=> (cnt_q == '0) && !flag_q); // R7
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl_en && !wr_cur) |=> $stable(cnt_q)); // R9
    AST_REF_GATES_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_en && !ctrl_src && !ref_en && !wr_cur) |=> $stable(cnt_q)); // R8
    AST_RELOAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n) wr_bad_reload |=> $stable(reload_q)); // R3
    AST_ZERO_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ((reload_q == '0) && (cnt_q == '0)) |=> (cnt_q == '0) && !tick_irq); // R10
endmodule

bind tick_timer_top tt_checker #(.DW(tt_pkg::DATA_W), .CW(tt_pkg::CNT_W), .AW(tt_pkg::ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .reload_q  (reload_q),
    .flag_q    (flag_q),
    .tick_irq  (tick_irq),
    .ctrl_en   (ctrl_en),
    .ctrl_int  (ctrl_int),
    .ctrl_src  (ctrl_src),
    .ref_en    (ref_en)
);

// File: tb/tb_tick_timer_top.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor pops and
// compares on each read and logs interrupt pulses.
module tb_tick_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_en = 1'b0;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    int sample_no = 0;
    int irq_log[$];
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    tick_timer_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_en    (ref_en),
        .tick_irq  (tick_irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge; each access uses one rising edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares read data and records interrupt samples.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            sample_no++;
            if (tick_irq === 1'b1) irq_log.push_back(sample_no);
            if (bus_rd) begin
                if (sb.size() == 0) begin
                    chk("SB unexpected read", bus_rdata, 32'h0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", {31'h0, tick_irq}, 32'h0);
        rd_exp(4'h0, 32'h0, "R1 control reset");
        rd_exp(4'h4, 32'h0, "R1 reload reset");
        rd_exp(4'h8, 32'h0, "R1 current reset");

        // R3 reload range
        wr(4'h4, 32'h0100_0000);
        rd_exp(4'h4, 32'h0, "R3 oversize reload rejected");
        wr(4'h4, 32'h00FF_FFFF);
        rd_exp(4'h4, 32'h00FF_FFFF, "R3 max reload stored");
        wr(4'h4, 32'h8000_0005);
        rd_exp(4'h4, 32'h00FF_FFFF, "R3 high-bit reload rejected");

        // R4 / R9 / R5 with reload 5 on the core clock
        wr(4'h4, 32'd5);
        wr(4'h0, 32'h5);
        idle(2);
        rd_exp(4'h8, 32'd4, "R4 count after wrap and one step");
        wr(4'h0, 32'h4);
        rd_exp(4'h8, 32'd2, "R9 value when stopped");
        idle(3);
        rd_exp(4'h8, 32'd2, "R9 value held while disabled");
        rd_exp(4'h0, 32'h0001_0004, "R5 flag set after wrap");
        rd_exp(4'h0, 32'h0000_0004, "R5 flag cleared by read");

        // R4 / R6 period and pulse width with reload 3
        wr(4'h4, 32'd3);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h7);
        irq_log.delete();
        idle(12);
        chk("R6 pulse count in 12 cycles", irq_log.size(), 32'd3);
        if (irq_log.size() == 3) begin
            chk("R4 period reload+1 first", irq_log[1] - irq_log[0], 32'd4);
            chk("R4 period reload+1 second", irq_log[2] - irq_log[1], 32'd4);
        end

        // R6 masked interrupt still sets flag
        wr(4'h0, 32'h5);
        wr(4'h8, 32'h0);
        irq_log.delete();
        idle(12);
        chk("R6 no pulse when masked", irq_log.size(), 32'd0);
        rd_exp(4'h0, 32'h0001_0005, "R6 flag set with interrupt masked");

        // R8 reference-enable source
        wr(4'h0, 32'h0);
        wr(4'h4, 32'd100);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h1);
        idle(5);
        rd_exp(4'h8, 32'd0, "R8 no step without ref_en");
        ref_en = 1'b1;
        idle(3);
        ref_en = 1'b0;
        rd_exp(4'h8, 32'd98, "R8 three ref_en steps");
        wr(4'h0, 32'h5);
        rd_exp(4'h8, 32'd98, "R8 core source takes effect next edge");
        idle(4);
        rd_exp(4'h8, 32'd93, "R8 core source steps every cycle");

        // R10 zero reload
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h0);
        rd_exp(4'h0, 32'h0, "R10 flag cleared before test");
        wr(4'h0, 32'h7);
        irq_log.delete();
        idle(10);
        chk("R10 no pulse with zero reload", irq_log.size(), 32'd0);
        rd_exp(4'h8, 32'd0, "R10 counter stays zero");
        rd_exp(4'h0, 32'h7, "R10 no flag with zero reload");

        // R7 current write on a wrap edge, then R5 read on a wrap edge
        wr(4'h0, 32'h0);
        wr(4'h4, 32'd2);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h5);
        wr(4'h8, 32'hDEAD_BEEF);
        rd_exp(4'h0, 32'h0000_0005, "R7 write beats coincident wrap");
        rd_exp(4'h8, 32'd2, "R7 wrap resumes after clear");
        rd_exp(4'h0, 32'h0001_0005, "R5 flag set despite read on wrap edge");
        rd_exp(4'h0, 32'h0000_0005, "R5 read on wrap edge sees old flag");
        rd_exp(4'h0, 32'h0001_0005, "R5 set wins over read clear");

        // R2 map details
        wr(4'h0, 32'h0001_0000);
        wr(4'h8, 32'h0);
        rd_exp(4'h0, 32'h0, "R2 flag bit not writable");
        rd_exp(4'hC, 32'h0, "R2 unmapped offset reads zero");
        wr(4'h0, 32'hFFFF_FFFF);
        rd_exp(4'h0, 32'h7, "R2 only control bits 2:0 stored");
        wr(4'h0, 32'h0);

        idle(2);
        chk("SB queue drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule